// File: doc/BRIEF.md
# Grouped Horizontal Scan-Chain LFSR

This block is the third expansion stage of a streaming scan-vector decompressor. It holds the scan cells that lie beyond the first bit-slice of a set of parallel scan chains. The chains are split into groups of equal size. Within a group, the segments are stitched end to end into one long modular LFSR. Each segment's first cell takes an injected bit from the upstream ring, so a group's injection points sit one segment length apart. The characteristic polynomial of every group is a parameter.

A test controller drives three controls. It keeps the feedback enable low for the first cycles of each new vector, so that the previous response drains out of the scan-out pins while fresh free-variables fill the segments. After that it raises the feedback enable, so that the stitching, the wrap and the polynomial taps let later injections mix into the whole group state. A capture strobe loads every cell in parallel, and the full cell contents are visible at all times for application to the logic under test.

Top module: `hlfsr_grouped`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every cell becomes 0 at that edge, whatever the other inputs are.
- R2: When both `cap_en` and `shift_en` are low, no cell changes.
- R3: When `cap_en` is high, every cell takes `cap_data` at the next edge, whatever the values of `shift_en` and `fb_en`. Cell j of chain c is bit c*SEG+j of both `cap_data` and `chain_state`, where SEG = CHAIN_LEN-1.
- R4: During a shift with `fb_en` low, each chain acts as an isolated shift register: cell 0 of chain c takes `inj[c]`, and cell j takes cell j-1.
- R5: During a shift with `fb_en` high, cell 0 of a chain that is not the first of its group takes `inj[c]` XOR the scan-out of chain c-1. Chain c belongs to group c/CHAINS_PER_GROUP.
- R6: During a shift with `fb_en` high, cell 0 of the first chain of a group takes `inj` XOR the scan-out of the last chain of that group. This bit is the group feedback.
- R7: During a shift with `fb_en` high, every group stage i > 0 whose bit is set in that group's slice of `TAPS` also XORs in the group feedback. Group stage i is cell i mod SEG of chain i/SEG within the group.
- R8: No group's state or injections affect any other group.
- R9: `scan_out[c]` always equals the last cell, SEG-1, of chain c.
- R10: Starting from any state, SEG shifts with `fb_en` low load any chosen pattern. The bit injected into a chain at shift t ends up in cell SEG-1-t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | Advance all group LFSRs by one step |
| fb_en | input | 1 | Enables the stitching, wrap and tap feedback |
| cap_en | input | 1 | Parallel load strobe; takes priority over shifting |
| inj | input | NUM_CHAINS | One injected bit per chain, from the upstream ring |
| cap_data | input | NUM_CHAINS*(CHAIN_LEN-1) | Parallel load value |
| chain_state | output | NUM_CHAINS*(CHAIN_LEN-1) | Full cell contents |
| scan_out | output | NUM_CHAINS | Last cell of each chain |

## Verification
Two functions can fall in the same cycle: the parallel capture and the shift, either with feedback or without it. The bench drives `cap_en` together with `shift_en` and `fb_en`, in directed steps and over long stretches of random control. A reference GF(2) model, built from the requirements, predicts capture priority on every edge, and the scoreboard compares both the cell contents and the scan-out bits after each edge. The feedback enable is also toggled in the middle of random injection sequences. This catches any error in the gating of the stitching, the wrap or the taps.

// File: rtl/hlfsr_pkg.sv
// Package: shared operation encoding for the grouped horizontal LFSR.
// Assumes nothing beyond the encoding being used consistently by all modules.
package hlfsr_pkg;

    // Per-cycle operation applied to the cell array.
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_CAPTURE = 2'd2
    } hlfsr_op_e;

endpackage

// File: rtl/hlfsr_op_decode.sv
// Module: hlfsr_op_decode
// Turns the raw strobes into one operation, with capture ahead of shift.
// Assumes the strobes are synchronous to the clock of the cell array.
module hlfsr_op_decode
    import hlfsr_pkg::*;
(
    input  logic      shift_en,
    input  logic      cap_en,
    output hlfsr_op_e op
);

    // Priority selection: capture, then shift, otherwise hold.
    always_comb begin
        if (cap_en) begin
            op = OP_CAPTURE;
        end else if (shift_en) begin
            op = OP_SHIFT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/hlfsr_group_next.sv
// Module: hlfsr_group_next
// Next-state logic of one group. The group is a modular LFSR made of
// CPG segments of SEG cells, joined end to end. Stage 0 of each segment
// receives an injection bit. The stitch between segments, the wrap from
// the last stage and the polynomial taps are all gated by fb_en.
// Assumes SEG >= 2. Bit 0 of TAPS is unused because stage 0 always
// takes the feedback.
module hlfsr_group_next #(
    parameter int CPG  = 2,
    parameter int SEG  = 4,
    parameter int GLEN = CPG * SEG,
    parameter logic [GLEN-1:0] TAPS = '0
) (
    input  logic [GLEN-1:0] cur,
    input  logic [CPG-1:0]  inj,
    input  logic            fb_en,
    output logic [GLEN-1:0] nxt
);

    logic fb;

    // Group feedback bit: the last stage, passed only while feedback is on.
    always_comb fb = cur[GLEN-1] & fb_en;

    for (genvar k = 0; k < CPG; k++) begin : g_seg
        for (genvar j = 0; j < SEG; j++) begin : g_cell
            localparam int I = k * SEG + j;
            if (I == 0) begin : g_head
                // First stage of the group: injection XOR wrap feedback.
                always_comb nxt[I] = inj[k] ^ fb;
            end else if (j == 0) begin : g_stitch
                // Segment entry: injection XOR the gated previous scan-out, plus tap.
                always_comb nxt[I] = inj[k] ^ (cur[I-1] & fb_en)
                                   ^ (TAPS[I] ? fb : 1'b0);
            end else begin : g_body
                // Plain stage: shift from the previous stage, plus tap.
                always_comb nxt[I] = cur[I-1] ^ (TAPS[I] ? fb : 1'b0);
            end
        end
    end

endmodule

// File: rtl/hlfsr_state_reg.sv
// Module: hlfsr_state_reg
// The cell array register. It resets, holds, takes the shifted next state
// or takes the parallel capture value, as the decoded operation selects.
// Assumes a synchronous active-low reset.
module hlfsr_state_reg
    import hlfsr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  hlfsr_op_e op,
    input  logic [W-1:0] shift_nxt,
    input  logic [W-1:0] cap_data,
    output logic [W-1:0] q
);

    // Cell array update with the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (op)
                OP_CAPTURE: q <= cap_data;
                OP_SHIFT:   q <= shift_nxt;
                default:    q <= q;
            endcase
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (q == '0)); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(q)); // R2

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CAPTURE) |=> (q == $past(cap_data))); // R3

endmodule

// File: rtl/hlfsr_grouped.sv
// Module: hlfsr_grouped
// Top level of the grouped horizontal scan-chain LFSR. It holds NUM_GROUPS
// groups of CHAINS_PER_GROUP chains, each with CHAIN_LEN-1 cells. The first
// bit-slice lives outside this block. Group g uses TAPS[g*GRP_LEN +: GRP_LEN]
// as its polynomial taps. Assumes CHAIN_LEN >= 3.
module hlfsr_grouped
    import hlfsr_pkg::*;
#(
    parameter int NUM_GROUPS       = 2,
    parameter int CHAINS_PER_GROUP = 2,
    parameter int CHAIN_LEN        = 5,
    parameter logic [NUM_GROUPS*CHAINS_PER_GROUP*(CHAIN_LEN-1)-1:0] TAPS = 16'h701C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic fb_en,
    input  logic cap_en,
    input  logic [NUM_GROUPS*CHAINS_PER_GROUP-1:0] inj,
    input  logic [NUM_GROUPS*CHAINS_PER_GROUP*(CHAIN_LEN-1)-1:0] cap_data,
    output logic [NUM_GROUPS*CHAINS_PER_GROUP*(CHAIN_LEN-1)-1:0] chain_state,
    output logic [NUM_GROUPS*CHAINS_PER_GROUP-1:0] scan_out
);

    localparam int NUM_CHAINS = NUM_GROUPS * CHAINS_PER_GROUP;
    localparam int SEG        = CHAIN_LEN - 1;
    localparam int GRP_LEN    = CHAINS_PER_GROUP * SEG;
    localparam int NUM_CELLS  = NUM_CHAINS * SEG;

    hlfsr_op_e            op;
    logic [NUM_CELLS-1:0] shift_nxt;

    hlfsr_op_decode u_dec (
        .shift_en (shift_en),
        .cap_en   (cap_en),
        .op       (op)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        hlfsr_group_next #(
            .CPG  (CHAINS_PER_GROUP),
            .SEG  (SEG),
            .GLEN (GRP_LEN),
            .TAPS (TAPS[g*GRP_LEN +: GRP_LEN])
        ) u_next (
            .cur   (chain_state[g*GRP_LEN +: GRP_LEN]),
            .inj   (inj[g*CHAINS_PER_GROUP +: CHAINS_PER_GROUP]),
            .fb_en (fb_en),
            .nxt   (shift_nxt[g*GRP_LEN +: GRP_LEN])
        );
    end

    hlfsr_state_reg #(.W(NUM_CELLS)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .shift_nxt (shift_nxt),
        .cap_data  (cap_data),
        .q         (chain_state)
    );

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_out
        localparam int FIRST_IN_GRP = (c / CHAINS_PER_GROUP) * CHAINS_PER_GROUP;
        localparam int LAST_IN_GRP  = FIRST_IN_GRP + CHAINS_PER_GROUP - 1;

        // Scan-out tap: the last cell of each chain.
        always_comb scan_out[c] = chain_state[c*SEG + SEG - 1];

        AST_DRAIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            (shift_en && !cap_en && !fb_en) |=> (chain_state[c*SEG] == $past(inj[c]))); // R4

        AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
            (shift_en && !cap_en && !fb_en) |=>
            (scan_out[c] == $past(chain_state[c*SEG + SEG - 2]))); // R4

        if (c == FIRST_IN_GRP) begin : g_wrap
            AST_WRAP_FEED: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_en && !cap_en && fb_en) |=>
                (chain_state[c*SEG] == $past(inj[c] ^ scan_out[LAST_IN_GRP]))); // R6
        end else begin : g_link
            AST_STITCH_FEED: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_en && !cap_en && fb_en && !TAPS[c*SEG]) |=>
                (chain_state[c*SEG] == $past(inj[c] ^ scan_out[c-1]))); // R5
        end
    end

endmodule

// File: tb/sim_hlfsr_grouped.sv
`timescale 1ns/1ps
module sim_hlfsr_grouped;

    localparam int NG    = 2;
    localparam int CPG   = 2;
    localparam int CLEN  = 5;
    localparam int SEG   = CLEN - 1;
    localparam int NCH   = NG * CPG;
    localparam int GL    = CPG * SEG;
    localparam int NCELL = NCH * SEG;
    localparam logic [NCELL-1:0] POLY = 16'h701C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_en = 1'b0, fb_en = 1'b0, cap_en = 1'b0;
    logic [NCH-1:0]   inj = '0;
    logic [NCELL-1:0] cap_data = '0;
    logic [NCELL-1:0] chain_state;
    logic [NCH-1:0]   scan_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [NCELL-1:0] ref_st = '0;
    logic [NCELL-1:0] exp_q[$];
    string            tag_q[$];

    always #4 clk = ~clk;

    hlfsr_grouped #(
        .NUM_GROUPS(NG), .CHAINS_PER_GROUP(CPG), .CHAIN_LEN(CLEN), .TAPS(POLY)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .fb_en(fb_en),
        .cap_en(cap_en), .inj(inj), .cap_data(cap_data),
        .chain_state(chain_state), .scan_out(scan_out)
    );

    // Reference GF(2) model written from the requirements.
    function automatic logic [NCELL-1:0] model(
        input logic [NCELL-1:0] cur, input logic rst, input logic cap,
        input logic shf, input logic fbe, input logic [NCH-1:0] ij,
        input logic [NCELL-1:0] capd);
        logic [NCELL-1:0] n;
        if (!rst) return '0;              // R1
        if (cap) return capd;             // R3
        if (!shf) return cur;             // R2
        n = '0;
        for (int g = 0; g < NG; g++) begin
            logic fbk;
            fbk = cur[g*GL + GL - 1] & fbe;
            for (int p = 0; p < GL; p++) begin
                int gi;
                logic b;
                gi = g*GL + p;
                if (p % SEG != 0)      b = cur[gi-1];           // R4 shift
                else if (p == 0)       b = fbk;                 // R6 wrap
                else                   b = cur[gi-1] & fbe;     // R5 stitch
                if (p % SEG == 0)      b ^= ij[g*CPG + p/SEG];
                if (p != 0 && POLY[gi]) b ^= fbk;               // R7 taps
                n[gi] = b;
            end
        end
        return n;
    endfunction

    function automatic logic [NCH-1:0] outs(input logic [NCELL-1:0] s);
        logic [NCH-1:0] o;
        for (int c = 0; c < NCH; c++) o[c] = s[c*SEG + SEG - 1];
        return o;
    endfunction

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input logic rst, input logic cap, input logic shf,
                        input logic fbe, input logic [NCH-1:0] ij,
                        input logic [NCELL-1:0] capd, input string tag);
        @(negedge clk);
        rst_n = rst; cap_en = cap; shift_en = shf; fb_en = fbe;
        inj = ij; cap_data = capd;
        ref_st = model(ref_st, rst, cap, shf, fbe, ij, capd);
        exp_q.push_back(ref_st);
        tag_q.push_back(tag);
    endtask

    // Monitor: pop and compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [NCELL-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (chain_state !== e) begin
                    n_bad++;
                    $display("FAIL %s state: actual %h expected %h", t, chain_state, e);
                end
                n_cmp++;
                if (scan_out !== outs(e)) begin
                    n_bad++;
                    $display("FAIL R9 scan_out: actual %b expected %b", scan_out, outs(e));
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [NCELL-1:0] tgt;
        // R1: reset clears everything, even with other controls active.
        for (int i = 0; i < 3; i++)
            step(1'b0, 1'b1, 1'b1, 1'b1, NCH'($urandom), NCELL'($urandom), "R1");
        // R2: idle holds.
        for (int i = 0; i < 2; i++)
            step(1'b1, 1'b0, 1'b0, 1'b1, NCH'($urandom), NCELL'($urandom), "R2");
        // R3: capture, then hold, then capture during a shift with feedback.
        step(1'b1, 1'b1, 1'b0, 1'b0, '0, NCELL'($urandom), "R3");
        for (int i = 0; i < 2; i++)
            step(1'b1, 1'b0, 1'b0, 1'b0, NCH'($urandom), '0, "R2");
        step(1'b1, 1'b1, 1'b1, 1'b1, NCH'($urandom), NCELL'($urandom), "R3");
        // R4: drain without feedback, old contents leave by scan_out.
        for (int i = 0; i < SEG; i++)
            step(1'b1, 1'b0, 1'b1, 1'b0, NCH'($urandom), '0, "R4");
        // R10: load a chosen pattern in SEG shifts with feedback off.
        step(1'b1, 1'b1, 1'b0, 1'b0, '0, NCELL'($urandom), "R3");
        tgt = NCELL'($urandom);
        for (int t = 0; t < SEG; t++) begin
            logic [NCH-1:0] v;
            for (int c = 0; c < NCH; c++) v[c] = tgt[c*SEG + SEG - 1 - t];
            step(1'b1, 1'b0, 1'b1, 1'b0, v, '0, "R10");
        end
        if (ref_st !== tgt) $display("note: model and target differ");
        // R6 R7: single one in a group's last stage, feedback on, no injection.
        step(1'b1, 1'b1, 1'b0, 1'b0, '0, NCELL'(1) << (GL - 1), "R3");
        for (int i = 0; i < 3 * GL; i++)
            step(1'b1, 1'b0, 1'b1, 1'b1, '0, '0, "R6 R7 R8");
        // R5 R8: random injections with feedback on.
        for (int i = 0; i < 300; i++)
            step(1'b1, 1'b0, 1'b1, 1'b1, NCH'($urandom), '0, "R5 R6 R7");
        // R8: random controls, including capture and shift together and fb toggling.
        for (int i = 0; i < 600; i++)
            step(1'b1, ($urandom % 8) == 0, $urandom % 4 != 0, 1'($urandom),
                 NCH'($urandom), NCELL'($urandom), "R8 R3");
        // R1: reset in mid-run.
        step(1'b0, 1'b0, 1'b1, 1'b1, NCH'($urandom), '0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, '0, '0, "R2");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule